// File: doc/BRIEF.md
# Two-Level Interrupt Controller with Grouped Sub-Sources

This block collects 32 main interrupt sources and 11 sub-sources and presents them to a processor as one request line plus the index of the source being served. Each main source has a latched pending bit and a mask bit. Four of the main positions are not driven from outside. Each is fed by a group of sub-sources that have their own pending and mask registers. Three groups of three sub-sources serve the serial ports. One group of two serves the converter and touch logic. A group drives its parent position whenever any of its unmasked sub-sources is pending.

Software reaches five registers through a single-cycle register port. The port takes a write enable, an address and write data, and returns read data combinationally. Pending registers are cleared by writing ones. A serving register holds at most one bit: the lowest-numbered pending, unmasked main source, captured only while nothing is being served. The request output follows that register, so software clears the served bit and the block then picks the next one.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, the main mask reads all ones, the sub mask reads 0x7FF, all three pending registers read zero, irq_req is 0 and irq_idx is 0.
- R2: For a main position that has no group, a 0-to-1 change of src_irq[i] sets main pending bit i at the next clock edge. The bit stays set until software clears it. An input that is still high after the clear does not set the bit again.
- R3: Writing data to address 0 (main pending) or address 2 (serving) clears every bit that is 1 in the data. Bits written as 0 are unchanged.
- R4: A 0-to-1 change of sub_irq[j] sets bit j of the sub pending register (address 3) at the next edge. Writing a 1 to that bit clears it.
- R5: Sub bits 0-2 feed main position 28, bits 3-5 feed position 23, bits 6-8 feed position 15 and bits 9-10 feed position 31. A parent bit is set on every clock where its group has a pending sub bit whose sub mask bit is 0. It therefore returns after a clear while that condition lasts.
- R6: While every sub-source of a group is masked, the parent bit is not set, although the sub pending bits still latch.
- R7: src_irq at positions 15, 23, 28 and 31 has no effect on the main pending register.
- R8: While the serving register is zero, it loads on the next edge a single bit: the lowest-numbered position that is set in main pending and 0 in the main mask. It never holds more than one bit.
- R9: While the serving register is non-zero, it keeps its value even when a lower-numbered source becomes pending. It changes only through a clear written to address 2.
- R10: irq_req is 1 exactly when the serving register is non-zero. irq_idx is the position of its set bit, or 0 when it is empty.
- R11: A main source whose mask bit is 1 still latches in main pending but is never loaded into the serving register.
- R12: Address 1 is the main mask and address 4 is the 11-bit sub mask. Both take the full written value. Addresses 5 to 7 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | 32 | Main request inputs; parent positions are ignored |
| sub_irq | input | 11 | Sub-source request inputs |
| bus_wen | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_idx | output | 5 | Index of the served source |

## Verification
The checker assumes that every request input is synchronous to clk and is low while reset is held. Without that, the first edge after reset would latch a request that the edge detector never saw rise. It also assumes that each bus write lasts one cycle and that nothing else changes the serving register. The bench drives all inputs on the falling edge, keeps requests low during reset, and raises each request only after the masks it depends on have been written.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int NSRC   = 32;
    localparam int NSUB   = 11;
    localparam int NGRP   = 4;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int ADDR_W = 3;
    localparam int BUS_W  = 32;

    typedef logic [NSRC-1:0] src_vec_t;
    typedef logic [NSUB-1:0] sub_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_SRC_PEND = 3'd0,
        SEL_SRC_MASK = 3'd1,
        SEL_SERVE    = 3'd2,
        SEL_SUB_PEND = 3'd3,
        SEL_SUB_MASK = 3'd4
    } reg_sel_e;

    typedef struct packed {
        src_vec_t src;
        src_vec_t serve;
        sub_vec_t sub;
    } clr_vec_t;

    // First sub bit of a group
    function automatic int grp_lo(input int g);
        case (g)
            0:       return 0;
            1:       return 3;
            2:       return 6;
            default: return 9;
        endcase
    endfunction

    // Last sub bit of a group
    function automatic int grp_hi(input int g);
        case (g)
            0:       return 2;
            1:       return 5;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

    // Main position driven by a group
    function automatic int grp_parent(input int g);
        case (g)
            0:       return 28;
            1:       return 23;
            2:       return 15;
            default: return 31;
        endcase
    endfunction

    function automatic src_vec_t parent_positions();
        src_vec_t v;
        v = '0;
        for (int g = 0; g < NGRP; g++) begin
            v[grp_parent(g)] = 1'b1;
        end
        return v;
    endfunction

    localparam src_vec_t PARENT_VEC = parent_positions();

    function automatic src_vec_t lowest_onehot(input src_vec_t v);
        return v & (~v + src_vec_t'(1));
    endfunction

    function automatic logic [IDX_W-1:0] onehot_index(input src_vec_t v);
        logic [IDX_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (v[i]) idx = idx | IDX_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/cic_pend_bank.sv
module cic_pend_bank #(
    parameter int               WIDTH      = 8,
    parameter logic [WIDTH-1:0] LEVEL_BITS = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] req,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] pend
);

    logic [WIDTH-1:0] req_q;
    logic [WIDTH-1:0] set_now;

    // Level positions set every cycle; the rest only on a rising input
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (LEVEL_BITS[i]) begin : g_level
            assign set_now[i] = req[i];
        end else begin : g_edge
            assign set_now[i] = req[i] & ~req_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            pend  <= '0;
        end else begin
            req_q <= req;
            pend  <= (pend & ~clr) | set_now;
        end
    end

endmodule

// File: rtl/cic_subgroup.sv
module cic_subgroup
    import cic_pkg::*;
(
    input  sub_vec_t sub_pend,
    input  sub_vec_t sub_mask,
    output src_vec_t parent_req
);

    sub_vec_t        live;
    logic [NGRP-1:0] grp_req;

    assign live = sub_pend & ~sub_mask;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = grp_lo(g);
        localparam int HI = grp_hi(g);
        assign grp_req[g] = |live[HI:LO];
    end

    always_comb begin
        parent_req = '0;
        for (int g = 0; g < NGRP; g++) begin
            parent_req[IDX_W'(grp_parent(g))] = grp_req[g];
        end
    end

endmodule

// File: rtl/cic_arbiter.sv
module cic_arbiter
    import cic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  src_vec_t         src_pend,
    input  src_vec_t         src_mask,
    input  src_vec_t         clr,
    output src_vec_t         serve,
    output logic             irq_req,
    output logic [IDX_W-1:0] irq_idx
);

    src_vec_t cand;

    assign cand = src_pend & ~src_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            serve <= '0;
        end else if (serve == '0) begin
            serve <= lowest_onehot(cand);
        end else begin
            serve <= serve & ~clr;
        end
    end

    assign irq_req = |serve;
    assign irq_idx = onehot_index(serve);

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import cic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_irq,
    input  logic [NSUB-1:0]   sub_irq,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq_req,
    output logic [IDX_W-1:0]  irq_idx
);

    reg_sel_e sel;
    clr_vec_t clr;
    src_vec_t src_pend;
    src_vec_t src_mask;
    src_vec_t int_pend;
    src_vec_t parent_req;
    src_vec_t main_req;
    sub_vec_t sub_pend;
    sub_vec_t sub_mask;

    assign sel = reg_sel_e'(bus_addr);

    // Write-one-to-clear strobes
    always_comb begin
        clr = '0;
        if (bus_wen) begin
            case (sel)
                SEL_SRC_PEND: clr.src   = bus_wdata;
                SEL_SERVE:    clr.serve = bus_wdata;
                SEL_SUB_PEND: clr.sub   = bus_wdata[NSUB-1:0];
                default:      clr       = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_mask <= '1;
            sub_mask <= '1;
        end else if (bus_wen) begin
            if (sel == SEL_SRC_MASK) src_mask <= bus_wdata;
            if (sel == SEL_SUB_MASK) sub_mask <= bus_wdata[NSUB-1:0];
        end
    end

    cic_pend_bank #(
        .WIDTH      (NSUB),
        .LEVEL_BITS ('0)
    ) u_sub_bank (
        .clk  (clk),
        .rst  (rst),
        .req  (sub_irq),
        .clr  (clr.sub),
        .pend (sub_pend)
    );

    cic_subgroup u_group (
        .sub_pend   (sub_pend),
        .sub_mask   (sub_mask),
        .parent_req (parent_req)
    );

    assign main_req = (src_irq & ~PARENT_VEC) | parent_req;

    cic_pend_bank #(
        .WIDTH      (NSRC),
        .LEVEL_BITS (PARENT_VEC)
    ) u_src_bank (
        .clk  (clk),
        .rst  (rst),
        .req  (main_req),
        .clr  (clr.src),
        .pend (src_pend)
    );

    cic_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .src_pend (src_pend),
        .src_mask (src_mask),
        .clr      (clr.serve),
        .serve    (int_pend),
        .irq_req  (irq_req),
        .irq_idx  (irq_idx)
    );

    always_comb begin
        case (sel)
            SEL_SRC_PEND: bus_rdata = src_pend;
            SEL_SRC_MASK: bus_rdata = src_mask;
            SEL_SERVE:    bus_rdata = int_pend;
            SEL_SUB_PEND: bus_rdata = BUS_W'(sub_pend);
            SEL_SUB_MASK: bus_rdata = BUS_W'(sub_mask);
            default:      bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cic_checker.sv
module cic_checker
    import cic_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   src_irq,
    input logic              bus_wen,
    input logic [ADDR_W-1:0] bus_addr,
    input src_vec_t          srcpnd,
    input src_vec_t          intpnd,
    input src_vec_t          mask,
    input sub_vec_t          subpnd,
    input sub_vec_t          submask,
    input logic              irq_req,
    input logic [IDX_W-1:0]  irq_idx
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (mask == '1 && submask == '1 && srcpnd == '0 && intpnd == '0 && subpnd == '0));

    assert_serve_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(intpnd));

    assert_serve_loads_R8: assert property (@(posedge clk) disable iff (rst)
        (intpnd == '0 && (srcpnd & ~mask) != '0) |=> intpnd != '0);

    assert_serve_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (intpnd != '0 && !(bus_wen && bus_addr == 3'd2)) |=> $stable(intpnd));

    assert_index_match_R10: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> intpnd[irq_idx]);

    assert_masked_skip_R11: assert property (@(posedge clk) disable iff (rst)
        (intpnd == '0) |=> (intpnd == '0 || (intpnd & $past(srcpnd & ~mask)) != '0));

    for (genvar i = 0; i < NSRC; i++) begin : g_main
        if (!PARENT_VEC[i]) begin : g_plain
            assert_edge_cause_R2: assert property (@(posedge clk) disable iff (rst)
                $rose(srcpnd[i]) |-> $past(src_irq[i]));
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_par
        localparam int LO = grp_lo(g);
        localparam int HI = grp_hi(g);
        localparam int PB = grp_parent(g);
        // R6 / R7: a parent only rises from an unmasked pending sub-source
        assert_parent_cause_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(srcpnd[PB]) |-> $past(|(subpnd[HI:LO] & ~submask[HI:LO])));
    end

endmodule

bind irq_cascade_ctrl cic_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .src_irq  (src_irq),
    .bus_wen  (bus_wen),
    .bus_addr (bus_addr),
    .srcpnd   (src_pend),
    .intpnd   (int_pend),
    .mask     (src_mask),
    .subpnd   (sub_pend),
    .submask  (sub_mask),
    .irq_req  (irq_req),
    .irq_idx  (irq_idx)
);

// File: tb/irq_cascade_ctrl_bench.sv
module irq_cascade_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam logic [31:0] PARENTS = 32'h9080_8000;

    typedef struct packed {
        logic [31:0] raw;
        logic [31:0] msk;
        logic        irq;
        logic [4:0]  idx;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{raw: 32'h0000_0001, msk: 32'h0000_0000, irq: 1'b1, idx: 5'd0},
        '{raw: 32'h0000_0300, msk: 32'h0000_0000, irq: 1'b1, idx: 5'd8},
        '{raw: 32'h4000_0020, msk: 32'h0000_0020, irq: 1'b1, idx: 5'd30},
        '{raw: 32'h0001_0000, msk: 32'hFFFF_FFFF, irq: 1'b0, idx: 5'd0},
        '{raw: 32'h8080_0000, msk: 32'h0000_0000, irq: 1'b0, idx: 5'd0},
        '{raw: 32'h0000_4004, msk: 32'h0000_0004, irq: 1'b1, idx: 5'd14},
        '{raw: 32'h2400_0000, msk: 32'h0000_0000, irq: 1'b1, idx: 5'd26},
        '{raw: 32'h0000_0000, msk: 32'h0000_0000, irq: 1'b0, idx: 5'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_irq = '0;
    logic [10:0] sub_irq = '0;
    logic        bus_wen = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;
    logic [4:0]  irq_idx;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cascade_ctrl u_irq_cascade_ctrl (
        .clk       (clk),
        .rst       (rst),
        .src_irq   (src_irq),
        .sub_irq   (sub_irq),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .irq_idx   (irq_idx)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic int parent_of(input int b);
        if (b < 3) return 28;
        if (b < 6) return 23;
        if (b < 9) return 15;
        return 31;
    endfunction

    task automatic quiet();
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0000_07FF);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        src_irq = '0;
        sub_irq = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd1, rv); chk("R1", "main mask", rv, 32'hFFFF_FFFF);
        rd(3'd4, rv); chk("R1", "sub mask", rv, 32'h0000_07FF);
        rd(3'd0, rv); chk("R1", "main pending", rv, 32'h0);
        rd(3'd2, rv); chk("R1", "serving", rv, 32'h0);
        rd(3'd3, rv); chk("R1", "sub pending", rv, 32'h0);
        chk("R1", "irq_req", 32'(irq_req), 32'h0);

        // Table walk: R2 R7 R8 R10 R11
        for (int k = 0; k < 8; k++) begin
            wr(3'd1, VEC[k].msk);
            src_irq = VEC[k].raw;
            @(negedge clk);
            @(negedge clk);
            chk("R10", $sformatf("vec%0d irq_req", k), 32'(irq_req), 32'(VEC[k].irq));
            chk("R8", $sformatf("vec%0d irq_idx", k), 32'(irq_idx), 32'(VEC[k].idx));
            rd(3'd0, rv);
            chk("R2", $sformatf("vec%0d pending (R7 R11)", k), rv, VEC[k].raw & ~PARENTS);
            quiet();
        end

        // R9 hold, R3 zero writes and clear, R2 no re-trigger
        wr(3'd1, 32'h0);
        src_irq[10] = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R8", "first served", 32'(irq_idx), 32'd10);
        src_irq[3] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "held despite lower", 32'(irq_idx), 32'd10);
        rd(3'd0, rv); chk("R9", "both pending", rv, 32'h0000_0408);
        wr(3'd2, 32'h0);
        chk("R3", "zero write to serving", 32'(irq_idx), 32'd10);
        wr(3'd0, 32'h0);
        rd(3'd0, rv); chk("R3", "zero write to pending", rv, 32'h0000_0408);
        wr(3'd2, 32'h0000_0400);
        chk("R3", "serving cleared", 32'(irq_req), 32'h0);
        @(negedge clk);
        chk("R8", "next lowest served", 32'(irq_idx), 32'd3);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd0, 32'h0000_0408);
        wr(3'd2, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
        rd(3'd0, rv); chk("R2", "held input not re-latched", rv, 32'h0);
        src_irq = '0;
        @(negedge clk);

        // R4 R5 mapping of every sub-source
        wr(3'd4, 32'h0);
        for (int b = 0; b < 11; b++) begin
            sub_irq[b] = 1'b1;
            @(negedge clk);
            sub_irq[b] = 1'b0;
            rd(3'd3, rv); chk("R4", $sformatf("sub%0d latched", b), rv, 32'h1 << b);
            @(negedge clk);
            rd(3'd0, rv); chk("R5", $sformatf("sub%0d parent", b), rv, 32'h1 << parent_of(b));
            wr(3'd3, 32'h1 << b);
            wr(3'd0, 32'hFFFF_FFFF);
            rd(3'd3, rv); chk("R4", $sformatf("sub%0d cleared", b), rv, 32'h0);
            rd(3'd0, rv); chk("R5", $sformatf("sub%0d parent cleared", b), rv, 32'h0);
        end

        // R5 full path to the request and level re-set of the parent
        wr(3'd1, ~(32'h1 << 23));
        sub_irq[4] = 1'b1;
        @(negedge clk);
        sub_irq[4] = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R10", "sub path irq_req", 32'(irq_req), 32'h1);
        chk("R5", "sub path index", 32'(irq_idx), 32'd23);
        wr(3'd0, 32'h1 << 23);
        rd(3'd0, rv); chk("R5", "parent returns after clear", rv, 32'h1 << 23);
        quiet();

        // R6 fully masked group
        wr(3'd4, 32'h0000_0600);
        sub_irq[10] = 1'b1;
        @(negedge clk);
        sub_irq[10] = 1'b0;
        repeat (3) @(negedge clk);
        rd(3'd3, rv); chk("R6", "masked sub still latches", rv, 32'h0000_0400);
        rd(3'd0, rv); chk("R6", "parent stays clear", rv, 32'h0);
        wr(3'd4, 32'h0);
        @(negedge clk);
        rd(3'd0, rv); chk("R6", "parent after unmask", rv, 32'h8000_0000);
        quiet();

        // R12 register map
        wr(3'd1, 32'h1234_5678);
        rd(3'd1, rv); chk("R12", "main mask value", rv, 32'h1234_5678);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, rv); chk("R12", "sub mask width", rv, 32'h0000_07FF);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, rv); chk("R12", "spare address reads zero", rv, 32'h0);
        rd(3'd1, rv); chk("R12", "spare write ignored", rv, 32'h1234_5678);
        rd(3'd7, rv); chk("R12", "address 7 reads zero", rv, 32'h0);

        // R1 reset mid-run restores masks
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd(3'd1, rv); chk("R1", "mask after second reset", rv, 32'hFFFF_FFFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule